// File: doc/BRIEF.md
# Framed Serial Word Transmitter

This block drains a first-word-fall-through transmit FIFO onto a synchronous serial link made of four lines: a bit clock, a frame strobe, a word strobe and a data line. A divider derives the bit period from the reference clock. Every outgoing word is 32 data bits, most significant bit first, followed by one parity bit whose sense (odd or even) is set by a configuration input.

A message opens when the block is idle and the FIFO holds data. The frame strobe is held for T1 bit periods. After a quiet delay of T2 periods the first word goes out, with the word strobe high for the whole word. While the FIFO still has data when a word ends, the block waits T3 periods and sends the next word inside the same frame. Once the FIFO is found empty at the end of a word, the message closes and a one-cycle done interrupt is raised. The host sets the divider, the three timings, the parity sense and the clock polarity through static inputs, and changes them only while the block is idle.

Top module: `framed_ser_tx`

## Requirements
- R1: One bit period lasts `cfg_div` reference cycles. A value of 0 or 1 gives 2 cycles. The bit clock runs continuously, and the frame and word strobes change only at bit period boundaries.
- R2: With `cfg_clk_inv` = 0, data changes together with the rising edge of `ser_clk` and is to be sampled on its falling edge, halfway through the bit. With `cfg_clk_inv` = 1 the clock is inverted, so the sampling edge is the rising edge. The receiver sees exactly 33 sampling edges per word.
- R3: `ser_frame` goes high once per message, for T1 (`cfg_t1`) bit periods. A message begins only from idle and only when `fifo_empty` is low.
- R4: The first word of a message starts T2 (`cfg_t2`) bit periods after `ser_frame` falls.
- R5: `ser_word` is high for exactly 33 bit periods per word. It is low outside words and is never high together with `ser_frame`.
- R6: When `fifo_empty` is low at the end of a word, the next word follows in the same frame after a gap of T3 (`cfg_t3`) bit periods with `ser_word` low.
- R7: A word is sent as data bit 31 down to bit 0, then the parity bit. With `cfg_odd` = 0 the 33 bits hold an even number of ones, and with `cfg_odd` = 1 an odd number. `ser_data` is low whenever `ser_word` is low.
- R8: A timing value of 0 in T1, T2 or T3 acts as 1 bit period.
- R9: When `fifo_empty` is high at the end of a word, the message ends. `done_irq` pulses for one reference cycle and both strobes stay low. A word that arrives later opens a new frame.
- R10: `fifo_pop` is high for one reference cycle per word, in the cycle in which `fifo_data` is taken. After a message, every word pushed has been popped.
- R11: During and after reset, `ser_frame`, `ser_word`, `ser_data`, `fifo_pop` and `done_irq` are low. A reset in the middle of a message returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_div | input | 16 | Reference cycles per bit period |
| cfg_t1 | input | 16 | Frame strobe width in bit periods |
| cfg_t2 | input | 16 | Frame-to-first-word delay in bit periods |
| cfg_t3 | input | 16 | Inter-word gap in bit periods |
| cfg_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| cfg_clk_inv | input | 1 | Inverts the output bit clock |
| fifo_empty | input | 1 | Transmit FIFO holds no word |
| fifo_data | input | 32 | Head word of the FIFO (first-word-fall-through) |
| fifo_pop | output | 1 | Takes the head word from the FIFO |
| ser_clk | output | 1 | Serial bit clock |
| ser_frame | output | 1 | Frame strobe |
| ser_word | output | 1 | Word strobe |
| ser_data | output | 1 | Serial data |
| done_irq | output | 1 | One-cycle pulse at the end of a message |

## Verification
The close of a word and a new word landing in the FIFO can fall on the same bit boundary. That boundary is where the block decides between a T3 gap and ending the message. The bench sends a one-word message and pushes a second word so that the FIFO turns non-empty exactly in the last reference cycle of the word. In that case it expects one frame, one T3 gap and a single done pulse. It then repeats the push one cycle later and expects the first message to close with a done pulse, followed by a second frame with its own T1 and T2.

// File: rtl/sftx_pkg.sv
package sftx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FRAME,
      ST_LEAD,
      ST_WORD,
      ST_GAP
   } sftx_state_e;
endpackage

// File: rtl/sftx_clkgen.sv
module sftx_clkgen #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] cfg_div,
   input  logic          cfg_inv,
   output logic          tick,
   output logic          ser_clk
);
   localparam logic [CW-1:0] MIN_DIV = CW'(2);

   logic [CW-1:0] cnt, cnt_nx, n_eff, n_last, half;
   logic          sclk_q;

   always_comb begin
      n_eff  = (cfg_div < MIN_DIV) ? MIN_DIV : cfg_div;
      n_last = n_eff - 1'b1;
      half   = n_eff >> 1;
      tick   = (cnt >= n_last);
      cnt_nx = tick ? '0 : cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         sclk_q <= 1'b1;
      end else begin
         cnt    <= cnt_nx;
         sclk_q <= (cnt_nx < half);
      end
   end

   assign ser_clk = sclk_q ^ cfg_inv;

   // R2
   bit_start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> sclk_q);
endmodule

// File: rtl/sftx_shift.sv
module sftx_shift #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          shift,
   input  logic          cfg_odd,
   input  logic [DW-1:0] din,
   output logic          dout
);
   localparam int FW = DW + 1;

   logic [FW-1:0] sreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sreg <= '0;
      else if (load)
         sreg <= {din, (^din) ^ cfg_odd};
      else if (shift)
         sreg <= {sreg[FW-2:0], 1'b0};
   end

   assign dout = sreg[FW-1];

   // R7
   par_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> ((^sreg) == $past(cfg_odd)));
endmodule

// File: rtl/sftx_seq.sv
module sftx_seq
   import sftx_pkg::*;
#(
   parameter int DW = 32,
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic [TW-1:0] cfg_t1,
   input  logic [TW-1:0] cfg_t2,
   input  logic [TW-1:0] cfg_t3,
   input  logic          fifo_empty,
   output logic          load,
   output logic          shift,
   output logic          frame_q,
   output logic          word_q,
   output logic          done_q
);
   localparam int FW  = DW + 1;
   localparam int BCW = $clog2(FW);

   sftx_state_e    st;
   logic [TW-1:0]  tcnt;
   logic [BCW-1:0] bcnt;

   function automatic logic [TW-1:0] less_one(input logic [TW-1:0] t);
      return (t == '0) ? '0 : t - 1'b1;
   endfunction

   assign load  = tick && ((st == ST_LEAD) || (st == ST_GAP)) &&
                  (tcnt == '0) && !fifo_empty;
   assign shift = tick && (st == ST_WORD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         tcnt    <= '0;
         bcnt    <= '0;
         frame_q <= 1'b0;
         word_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (tick) begin
            case (st)
               ST_IDLE: if (!fifo_empty) begin
                  st      <= ST_FRAME;
                  frame_q <= 1'b1;
                  tcnt    <= less_one(cfg_t1);
               end
               ST_FRAME: if (tcnt == '0) begin
                  st      <= ST_LEAD;
                  frame_q <= 1'b0;
                  tcnt    <= less_one(cfg_t2);
               end else begin
                  tcnt <= tcnt - 1'b1;
               end
               ST_LEAD, ST_GAP: if (tcnt != '0) begin
                  tcnt <= tcnt - 1'b1;
               end else if (load) begin
                  st     <= ST_WORD;
                  word_q <= 1'b1;
                  bcnt   <= BCW'(FW - 1);
               end
               ST_WORD: if (bcnt == '0) begin
                  word_q <= 1'b0;
                  if (!fifo_empty) begin
                     st   <= ST_GAP;
                     tcnt <= less_one(cfg_t3);
                  end else begin
                     st     <= ST_IDLE;
                     done_q <= 1'b1;
                  end
               end else begin
                  bcnt <= bcnt - 1'b1;
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   // R5
   frame_word_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(frame_q && word_q));
   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   // R9
   done_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> $fell(word_q));
   // R10
   word_from_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(word_q) |-> $past(load));
   // R1
   strobe_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable({frame_q, word_q}));
endmodule

// File: rtl/framed_ser_tx.sv
module framed_ser_tx #(
   parameter int DW = 32,
   parameter int TW = 16,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] cfg_div,
   input  logic [TW-1:0] cfg_t1,
   input  logic [TW-1:0] cfg_t2,
   input  logic [TW-1:0] cfg_t3,
   input  logic          cfg_odd,
   input  logic          cfg_clk_inv,
   input  logic          fifo_empty,
   input  logic [DW-1:0] fifo_data,
   output logic          fifo_pop,
   output logic          ser_clk,
   output logic          ser_frame,
   output logic          ser_word,
   output logic          ser_data,
   output logic          done_irq
);
   generate
      if (DW < 2) begin : g_dw_chk
         $error("framed_ser_tx: DW must be at least 2");
      end
      if (TW < 2) begin : g_tw_chk
         $error("framed_ser_tx: TW must be at least 2");
      end
      if (CW < 2) begin : g_cw_chk
         $error("framed_ser_tx: CW must be at least 2");
      end
   endgenerate

   logic tick, load, shift;

   sftx_clkgen #(.CW(CW)) u_clkgen (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_div (cfg_div),
      .cfg_inv (cfg_clk_inv),
      .tick    (tick),
      .ser_clk (ser_clk)
   );

   sftx_seq #(.DW(DW), .TW(TW)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .cfg_t1     (cfg_t1),
      .cfg_t2     (cfg_t2),
      .cfg_t3     (cfg_t3),
      .fifo_empty (fifo_empty),
      .load       (load),
      .shift      (shift),
      .frame_q    (ser_frame),
      .word_q     (ser_word),
      .done_q     (done_irq)
   );

   sftx_shift #(.DW(DW)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .shift   (shift),
      .cfg_odd (cfg_odd),
      .din     (fifo_data),
      .dout    (ser_data)
   );

   assign fifo_pop = load;

   // R7
   data_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ser_word |-> !ser_data);
endmodule

// File: tb/framed_ser_tx_tb.sv
`timescale 1ns/1ps
module framed_ser_tx_tb;
   localparam int NV = 6;
   localparam int V_DIV [NV] = '{8, 8, 0, 5, 1, 3};
   localparam int V_T1  [NV] = '{1, 3, 0, 2, 7, 1};
   localparam int V_T2  [NV] = '{1, 5, 0, 1, 3, 2};
   localparam int V_T3  [NV] = '{1, 2, 0, 4, 0, 3};
   localparam int V_ODD [NV] = '{0, 1, 0, 1, 1, 0};
   localparam int V_INV [NV] = '{0, 0, 1, 1, 0, 0};
   localparam int V_N   [NV] = '{1, 3, 4, 2, 5, 2};
   localparam int V_SEED[NV] = '{1, 77, 4242, 9, 31337, 2024};

   logic        clk, rst_n;
   logic [15:0] cfg_div, cfg_t1, cfg_t2, cfg_t3;
   logic        cfg_odd, cfg_clk_inv;
   logic        fifo_empty;
   logic [31:0] fifo_data;
   logic        fifo_pop, ser_clk, ser_frame, ser_word, ser_data, done_irq;

   int total = 0, bad = 0;

   framed_ser_tx u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_t1(cfg_t1),
      .cfg_t2(cfg_t2), .cfg_t3(cfg_t3), .cfg_odd(cfg_odd),
      .cfg_clk_inv(cfg_clk_inv), .fifo_empty(fifo_empty),
      .fifo_data(fifo_data), .fifo_pop(fifo_pop), .ser_clk(ser_clk),
      .ser_frame(ser_frame), .ser_word(ser_word), .ser_data(ser_data),
      .done_irq(done_irq)
   );

   initial clk = 1'b0;
   always #2.5 clk = ~clk;

   // FIFO model, first-word-fall-through
   logic [31:0] q[$];
   logic        push_v = 1'b0;
   logic [31:0] push_d = '0;
   initial begin
      fifo_empty = 1'b1;
      fifo_data  = '0;
   end
   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete();
      end else begin
         if (fifo_pop && q.size() > 0) void'(q.pop_front());
         if (push_v) q.push_back(push_d);
      end
      fifo_empty <= (q.size() == 0);
      fifo_data  <= (q.size() > 0) ? q[0] : '0;
   end

   // line monitor
   int frames, dones, pops, hi_f, hi_w, lo_cnt, nb, fp;
   bit lead_mode, pf, pw, psc;
   logic [32:0] cap;
   int t1_meas[$], lead_meas[$], gap_meas[$], wlen[$], nbits[$], phase[$];
   logic [32:0] rx[$];

   always @(negedge clk) begin
      if (rst_n) begin
         if (fifo_pop) pops++;
         if (done_irq) dones++;
         if (ser_frame && !pf) frames++;
         if (ser_frame) hi_f++;
         else if (pf) begin
            t1_meas.push_back(hi_f);
            hi_f = 0;
            lo_cnt = 0;
            lead_mode = 1'b1;
         end
         if (ser_word) begin
            if (!pw) begin
               if (lead_mode) lead_meas.push_back(lo_cnt);
               else gap_meas.push_back(lo_cnt);
               lead_mode = 1'b0;
               cap = '0; nb = 0; hi_w = 0; fp = 0;
            end
            hi_w++;
            if (ser_clk != psc && ser_clk == cfg_clk_inv) begin
               if (nb == 0) fp = hi_w;
               cap = {cap[31:0], ser_data};
               nb++;
            end
         end else begin
            if (pw) begin
               wlen.push_back(hi_w);
               rx.push_back(cap);
               nbits.push_back(nb);
               phase.push_back(fp);
               lo_cnt = 0;
            end
            lo_cnt++;
         end
      end
      pf = ser_frame;
      pw = ser_word;
      psc = ser_clk;
   end

   logic [31:0] wbuf[16];

   task automatic chk(input string tag, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic clear_mon();
      @(posedge clk);
      frames = 0; dones = 0; pops = 0; hi_f = 0; hi_w = 0; lo_cnt = 0;
      nb = 0; fp = 0; lead_mode = 1'b0;
      t1_meas.delete(); lead_meas.delete(); gap_meas.delete();
      wlen.delete(); nbits.delete(); phase.delete(); rx.delete();
   endtask

   task automatic set_cfg(input int dv, input int a, input int b, input int c,
                          input int odd, input int inv);
      @(negedge clk);
      cfg_div = 16'(dv); cfg_t1 = 16'(a); cfg_t2 = 16'(b); cfg_t3 = 16'(c);
      cfg_odd = odd[0]; cfg_clk_inv = inv[0];
   endtask

   task automatic push_word(input logic [31:0] w);
      push_v = 1'b1;
      push_d = w;
      @(negedge clk);
      push_v = 1'b0;
   endtask

   task automatic wait_done(input int target);
      int c = 0;
      while (dones < target && c < 40000) begin
         @(posedge clk);
         c++;
      end
      repeat (40) @(posedge clk);
   endtask

   function automatic logic [32:0] frame_of(input logic [31:0] w, input bit odd);
      bit p = ($countones(w) % 2 == 1) ^ odd;
      return {w, p};
   endfunction

   task automatic run_msg(input int nw, input int dv, input int a, input int b,
                          input int c, input int odd, input int inv);
      int ne = (dv < 2) ? 2 : dv;
      int e1 = (a == 0) ? 1 : a;
      int e2 = (b == 0) ? 1 : b;
      int e3 = (c == 0) ? 1 : c;
      set_cfg(dv, a, b, c, odd, inv);
      clear_mon();
      @(negedge clk);
      for (int k = 0; k < nw; k++) push_word(wbuf[k]);
      wait_done(1);
      chk("R3 frame count", frames, 1);
      chk((a == 0) ? "R8 T1 width" : "R3 T1 width",
          (t1_meas.size() == 1) ? t1_meas[0] : -1, e1 * ne);
      chk((b == 0) ? "R8 T2 delay" : "R4 T2 delay",
          (lead_meas.size() == 1) ? lead_meas[0] : -1, e2 * ne);
      chk("R6 gap count", gap_meas.size(), nw - 1);
      for (int k = 0; k < gap_meas.size(); k++)
         chk((c == 0) ? "R8 T3 gap" : "R6 T3 gap", gap_meas[k], e3 * ne);
      chk("R5 word count", wlen.size(), nw);
      for (int k = 0; k < wlen.size() && k < nw; k++) begin
         chk((dv < 2) ? "R1 word length" : "R5 word length", wlen[k], 33 * ne);
         chk("R2 sample edges", nbits[k], 33);
         chk("R2 sample phase", phase[k], ne / 2 + 1);
         chk("R7 word bits", rx[k], frame_of(wbuf[k], odd[0]));
      end
      chk("R9 done pulses", dones, 1);
      chk("R10 pop count", pops, nw);
      chk("R10 fifo drained", q.size(), 0);
      chk("R9 strobes idle", {ser_frame, ser_word}, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      cfg_div = 16'd8; cfg_t1 = 16'd1; cfg_t2 = 16'd1; cfg_t3 = 16'd1;
      cfg_odd = 1'b0; cfg_clk_inv = 1'b0;
      repeat (4) @(negedge clk);
      // R11 reset state
      chk("R11 reset outputs",
          {ser_frame, ser_word, ser_data, fifo_pop, done_irq}, 0);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      chk("R11 idle after reset", {ser_frame, ser_word, ser_data, done_irq}, 0);

      // vector table
      for (int v = 0; v < NV; v++) begin
         for (int k = 0; k < V_N[v]; k++)
            wbuf[k] = 32'(V_SEED[v]) * 32'h0100_0193 + 32'(k) * 32'h9E37_79B9;
         run_msg(V_N[v], V_DIV[v], V_T1[v], V_T2[v], V_T3[v], V_ODD[v], V_INV[v]);
      end

      // R7 parity corners, both senses
      wbuf[0] = 32'h0000_0000; wbuf[1] = 32'hFFFF_FFFF; wbuf[2] = 32'h8000_0001;
      run_msg(3, 4, 1, 1, 1, 1, 0);
      run_msg(3, 2, 2, 1, 1, 0, 1);

      // R6 push lands in the last cycle of a word: gap, same frame
      wbuf[0] = 32'hA5A5_0F0F; wbuf[1] = 32'h1234_5678;
      set_cfg(4, 1, 1, 2, 0, 0);
      clear_mon();
      @(negedge clk);
      push_word(wbuf[0]);
      do @(negedge clk); while (!ser_word);
      repeat (33 * 4 - 2) @(negedge clk);
      push_word(wbuf[1]);
      wait_done(1);
      chk("R6 on-time push frames", frames, 1);
      chk("R6 on-time push gap", (gap_meas.size() == 1) ? gap_meas[0] : -1, 8);
      chk("R9 on-time push done", dones, 1);
      chk("R7 on-time second word", (rx.size() == 2) ? rx[1] : 0,
          frame_of(wbuf[1], 1'b0));

      // R9 push one cycle late: message closes, new frame opens
      set_cfg(4, 1, 1, 2, 0, 0);
      clear_mon();
      @(negedge clk);
      push_word(wbuf[0]);
      do @(negedge clk); while (!ser_word);
      repeat (33 * 4 - 1) @(negedge clk);
      push_word(wbuf[1]);
      wait_done(2);
      chk("R9 late push frames", frames, 2);
      chk("R9 late push done", dones, 2);
      chk("R9 late push gaps", gap_meas.size(), 0);
      chk("R4 late push delays", lead_meas.size(), 2);
      chk("R10 late push pops", pops, 2);

      // R11 reset in the middle of a message
      set_cfg(4, 2, 2, 2, 0, 0);
      clear_mon();
      @(negedge clk);
      push_word(32'hDEAD_BEEF);
      push_word(32'h0BAD_F00D);
      do @(negedge clk); while (!ser_word);
      repeat (10) @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R11 mid-message reset",
          {ser_frame, ser_word, ser_data, fifo_pop, done_irq}, 0);
      rst_n = 1'b1;
      repeat (100) @(negedge clk);
      chk("R11 stays idle after reset", {ser_frame, ser_word, ser_data}, 0);

      // recovery after reset
      wbuf[0] = 32'h7E57_0001;
      run_msg(1, 3, 1, 1, 1, 1, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule